// File: doc/BRIEF.md
# Wrapping-Counter Stream Engine

The engine walks an address window in three local RAMs. After a start pulse it reads operand RAMs A and B at consecutive addresses, starting at a programmed offset, for a programmed number of elements. For each element it combines the two operands with the current value of an internal element counter and writes the result into RAM C at the address the operands came from. Control is a start pulse with the offset and count beside it, and status is a busy level and a one-cycle done pulse. Software starts a pass and waits for done before it reads C.

The counter begins every pass at a fixed initial value and moves by a fixed step for each element. When it reaches the wrap limit it does not fold back modulo its size. In the default variant it jumps to a separate reload value, so after the first pass through the range it cycles over a shorter sub-range. A parameter selects plain modulo wrap instead.

The RAM ports have no handshake. Every RAM accepts an access in every cycle and returns read data one cycle after the address, so the engine never meets back-pressure. It issues one element per cycle until the window is done. The counter value and the write address are held back one stage so that they meet the read data.

Top module: `strm_wrap_engine`

## Requirements
- R1: Element k of a pass reads A and B, and writes C, at address (offset + k) mod 2^AW, for k = 0 to count-1. No other address of C is written.
- R2: The value written for each element is a + b - a - b + x, taken modulo 2^DW, where x is the counter value for that element. The written word therefore equals x.
- R3: The counter holds 6 for the first element of every pass, including a pass that follows another. It advances by the step, 1, only for elements that are issued.
- R4: With reload enabled (the default): when the count is at least size minus step (size 8), the next count is the reload value 2. Otherwise it is count plus step. The per-element sequence is 6, 7, 2, 3, 4, 5, 6, 7, 2, ...
- R5: With reload disabled: the wrap gives count plus step minus size. The sequence is 6, 7, 0, 1, ..., 7, 0, ...
- R6: RAM reads have one cycle of latency. The first write to C happens in the second cycle after the cycle in which start is accepted. Writes then follow on consecutive cycles.
- R7: A start pulse while busy is high has no effect on addresses, counts or writes. A start in the cycle where done is high is accepted.
- R8: Busy is high from the cycle after an accepted nonzero start through the cycle of the last C write. Done is high for exactly the one cycle after the last C write, that is, count+2 cycles after the start cycle.
- R9: A count of zero causes no RAM write, leaves busy low, and raises done in the cycle after start.
- R10: After reset, busy, done and the C write enable are all low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start pulse, taken only while busy is low |
| start_ofs | input | AW | First address of the window |
| elem_cnt | input | AW+1 | Number of elements, 0 to 2^AW |
| busy | output | 1 | Pass in progress |
| done | output | 1 | One-cycle pulse at end of pass |
| a_addr | output | AW | Read address of RAM A |
| a_rdata | input | DW | Read data of RAM A, one cycle after address |
| b_addr | output | AW | Read address of RAM B |
| b_rdata | input | DW | Read data of RAM B, one cycle after address |
| c_addr | output | AW | Write address of RAM C |
| c_we | output | 1 | Write enable of RAM C |
| c_wdata | output | DW | Write data of RAM C |

## Verification
Two things can happen in the same cycle. The done pulse of one pass can meet the acceptance of the next start, and the last write of a pass can meet a start pulse that must be ignored. The bench raises start in exactly the done cycle and then checks two things: that the second window is filled with a counter sequence that starts again at 6, and that the second latency is the full count+2. It also pulses start with a different window in the middle of a pass and checks that C stays untouched there and that the total number of writes does not change.

// File: rtl/strm_eng_pkg.sv
package strm_eng_pkg;
  // Per-element control carried alongside a read address.
  typedef struct packed {
    logic valid;
    logic last;
  } elem_tag_t;
endpackage

// File: rtl/strm_addr_gen.sv
module strm_addr_gen
  import strm_eng_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic [AW-1:0] ofs,
  input  logic [AW:0]   len,
  output elem_tag_t     tag,
  output logic [AW-1:0] addr
);
  localparam logic [AW:0] ONE = {{AW{1'b0}}, 1'b1};

  logic          iss_q;
  logic [AW-1:0] addr_q;
  logic [AW:0]   left_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      iss_q  <= 1'b0;
      addr_q <= '0;
      left_q <= '0;
    end else if (accept && len != '0) begin
      iss_q  <= 1'b1;
      addr_q <= ofs;
      left_q <= len;
    end else if (iss_q) begin
      addr_q <= addr_q + 1'b1;
      left_q <= left_q - ONE;
      if (left_q == ONE) iss_q <= 1'b0;
    end
  end

  assign addr      = addr_q;
  assign tag.valid = iss_q;
  assign tag.last  = iss_q && (left_q == ONE);

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_q && left_q != ONE) |=> (iss_q && addr_q == $past(addr_q) + 1'b1)); // R1
  AST_ACCEPT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> !iss_q); // R7
endmodule

// File: rtl/strm_wrap_cnt.sv
module strm_wrap_cnt #(
  parameter int CW         = 32,
  parameter int INIT       = 6,
  parameter int SIZE       = 8,
  parameter int STEP       = 1,
  parameter int RELOAD     = 2,
  parameter bit USE_RELOAD = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic          adv,
  output logic [CW-1:0] value
);
  localparam logic [CW-1:0] INIT_V = CW'(INIT);
  localparam logic [CW-1:0] LIM_V  = CW'(SIZE - STEP);
  localparam logic [CW-1:0] STEP_V = CW'(STEP);
  localparam logic [CW-1:0] SIZE_V = CW'(SIZE);
  localparam logic [CW-1:0] RLD_V  = CW'(RELOAD);

  logic [CW-1:0] q;
  logic [CW-1:0] nxt;

  generate
    if (USE_RELOAD) begin : g_reload
      always_comb nxt = (q >= LIM_V) ? RLD_V : q + STEP_V;
      AST_CNT_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !restart && q >= LIM_V) |=> (q == RLD_V)); // R4
    end else begin : g_modulo
      always_comb nxt = (q >= LIM_V) ? q + STEP_V - SIZE_V : q + STEP_V;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n)       q <= INIT_V;
    else if (restart) q <= INIT_V;
    else if (adv)     q <= nxt;
  end

  assign value = q;

  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && !restart) |=> $stable(q)); // R3
  AST_CNT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (q == INIT_V)); // R3
endmodule

// File: rtl/strm_align.sv
module strm_align
  import strm_eng_pkg::*;
#(
  parameter int AW = 10,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  elem_tag_t     tag,
  input  logic [AW-1:0] rd_addr,
  input  logic [DW-1:0] x,
  input  logic [DW-1:0] a_rdata,
  input  logic [DW-1:0] b_rdata,
  input  logic          zero_start,
  output logic          wr_v,
  output logic [AW-1:0] c_addr,
  output logic [DW-1:0] c_wdata,
  output logic          done
);
  logic          wr_last;
  logic [AW-1:0] wa_q;
  logic [DW-1:0] x_q;
  logic          done_q;

  // One stage matching the RAM read latency.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_v    <= 1'b0;
      wr_last <= 1'b0;
      wa_q    <= '0;
      x_q     <= '0;
      done_q  <= 1'b0;
    end else begin
      wr_v    <= tag.valid;
      wr_last <= tag.last;
      if (tag.valid) begin
        wa_q <= rd_addr;
        x_q  <= x;
      end
      done_q <= zero_start || (wr_v && wr_last);
    end
  end

  assign c_addr  = wa_q;
  assign c_wdata = a_rdata + b_rdata - a_rdata - b_rdata + x_q;
  assign done    = done_q;

  AST_DONE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q); // R8
  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_v && wr_last) |=> (done_q && !wr_v)); // R8
  AST_WR_FOLLOWS_RD: assert property (@(posedge clk) disable iff (!rst_n)
    tag.valid |=> (wr_v && wa_q == $past(rd_addr))); // R6
endmodule

// File: rtl/strm_wrap_engine.sv
module strm_wrap_engine
  import strm_eng_pkg::*;
#(
  parameter int AW         = 10,
  parameter int DW         = 32,
  parameter int CNT_INIT   = 6,
  parameter int CNT_SIZE   = 8,
  parameter int CNT_STEP   = 1,
  parameter int CNT_RELOAD = 2,
  parameter bit USE_RELOAD = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] start_ofs,
  input  logic [AW:0]   elem_cnt,
  output logic          busy,
  output logic          done,
  output logic [AW-1:0] a_addr,
  input  logic [DW-1:0] a_rdata,
  output logic [AW-1:0] b_addr,
  input  logic [DW-1:0] b_rdata,
  output logic [AW-1:0] c_addr,
  output logic          c_we,
  output logic [DW-1:0] c_wdata
);
  elem_tag_t     tag;
  logic [AW-1:0] rd_addr;
  logic [DW-1:0] x;
  logic          wr_v;
  logic          accept;
  logic          zero_start;

  assign busy       = tag.valid | wr_v;
  assign accept     = start & ~busy;
  assign zero_start = accept && (elem_cnt == '0);

  strm_addr_gen #(.AW(AW)) u_gen (
    .clk(clk), .rst_n(rst_n), .accept(accept), .ofs(start_ofs),
    .len(elem_cnt), .tag(tag), .addr(rd_addr)
  );

  strm_wrap_cnt #(
    .CW(DW), .INIT(CNT_INIT), .SIZE(CNT_SIZE), .STEP(CNT_STEP),
    .RELOAD(CNT_RELOAD), .USE_RELOAD(USE_RELOAD)
  ) u_cnt (
    .clk(clk), .rst_n(rst_n), .restart(accept), .adv(tag.valid), .value(x)
  );

  strm_align #(.AW(AW), .DW(DW)) u_align (
    .clk(clk), .rst_n(rst_n), .tag(tag), .rd_addr(rd_addr), .x(x),
    .a_rdata(a_rdata), .b_rdata(b_rdata), .zero_start(zero_start),
    .wr_v(wr_v), .c_addr(c_addr), .c_wdata(c_wdata), .done(done)
  );

  assign a_addr = rd_addr;
  assign b_addr = rd_addr;
  assign c_we   = wr_v;

  AST_WE_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    c_we |-> busy); // R8
  AST_ZERO_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    zero_start |=> (done && !busy)); // R9
  AST_BUSY_IGNORES: assert property (@(posedge clk) disable iff (!rst_n)
    (start && busy && tag.valid && !tag.last) |=> (a_addr == $past(a_addr) + 1'b1)); // R7
  AST_NO_DONE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R8
endmodule

// File: tb/sim_strm_wrap_engine.sv
`timescale 1ns/1ps
module tb_mem #(
  parameter int AW = 10,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          clr,
  input  logic [AW-1:0] a_addr,
  input  logic [AW-1:0] b_addr,
  input  logic [AW-1:0] c_addr,
  input  logic          c_we,
  input  logic [DW-1:0] c_wdata,
  output logic [DW-1:0] a_rdata,
  output logic [DW-1:0] b_rdata
);
  logic [DW-1:0] mc [2**AW];
  int wcnt;
  always @(posedge clk) begin
    a_rdata <= DW'(a_addr) * 32'h9E3779B1 + 32'd17;
    b_rdata <= ~(DW'(b_addr) * 32'h000085EB + 32'd3);
    if (clr) begin
      for (int i = 0; i < 2**AW; i++) mc[i] <= 32'hDEADBEEF;
      wcnt <= 0;
    end else if (c_we) begin
      mc[c_addr] <= c_wdata;
      wcnt <= wcnt + 1;
    end
  end
endmodule

module sim_strm_wrap_engine;
  localparam int AW = 10;
  localparam int DW = 32;
  localparam int DEPTH = 2**AW;
  localparam logic [31:0] SENT = 32'hDEADBEEF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clr = 1'b1;
  logic start = 1'b0;
  logic [AW-1:0] ofs = '0;
  logic [AW:0] len = '0;

  logic busy0, done0, cwe0, busy1, done1, cwe1;
  logic [AW-1:0] aa0, ba0, ca0, aa1, ba1, ca1;
  logic [DW-1:0] ar0, br0, cd0, ar1, br1, cd1;

  int nchk = 0;
  int nfail = 0;

  always #2.5 clk = ~clk;

  strm_wrap_engine #(.AW(AW), .DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .start_ofs(ofs), .elem_cnt(len),
    .busy(busy0), .done(done0), .a_addr(aa0), .a_rdata(ar0), .b_addr(ba0),
    .b_rdata(br0), .c_addr(ca0), .c_we(cwe0), .c_wdata(cd0)
  );
  strm_wrap_engine #(.AW(AW), .DW(DW), .USE_RELOAD(1'b0)) u1 (
    .clk(clk), .rst_n(rst_n), .start(start), .start_ofs(ofs), .elem_cnt(len),
    .busy(busy1), .done(done1), .a_addr(aa1), .a_rdata(ar1), .b_addr(ba1),
    .b_rdata(br1), .c_addr(ca1), .c_we(cwe1), .c_wdata(cd1)
  );
  tb_mem #(.AW(AW), .DW(DW)) m0 (
    .clk(clk), .clr(clr), .a_addr(aa0), .b_addr(ba0), .c_addr(ca0),
    .c_we(cwe0), .c_wdata(cd0), .a_rdata(ar0), .b_rdata(br0)
  );
  tb_mem #(.AW(AW), .DW(DW)) m1 (
    .clk(clk), .clr(clr), .a_addr(aa1), .b_addr(ba1), .c_addr(ca1),
    .c_we(cwe1), .c_wdata(cd1), .a_rdata(ar1), .b_rdata(br1)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_mem();
    @(negedge clk) clr = 1'b1;
    @(negedge clk) clr = 1'b0;
  endtask

  // Called at a negedge; returns at sample 1 (negedge after the start edge).
  task automatic launch(input int o, input int n);
    start = 1'b1;
    ofs = AW'(o);
    len = (AW+1)'(n);
    @(negedge clk);
    start = 1'b0;
  endtask

  // Polls from sample 1; lat is the sample index where done is seen.
  task automatic wait_done(output int lat, output int first_we, output logic b_at1);
    lat = 1;
    first_we = 0;
    b_at1 = busy0;
    while (!done0 && lat < 3000) begin
      if (cwe0 && first_we == 0) first_we = lat;
      @(negedge clk);
      lat++;
    end
    if (!done0) begin
      nfail++;
      $display("FAIL R8 done timeout actual=0 expected=1");
    end
  endtask

  // R1 R2 R3 R4 R5: window content of both variants.
  task automatic verify_window(input int o, input int n);
    logic [31:0] v0, v1;
    v0 = 32'd6;
    v1 = 32'd6;
    for (int k = 0; k < n; k++) begin
      chk("R2 R3 R4 data reload", m0.mc[(o + k) % DEPTH], v0);
      chk("R5 data modulo", m1.mc[(o + k) % DEPTH], v1);
      v0 = (v0 >= 32'd7) ? 32'd2 : v0 + 32'd1;
      v1 = (v1 >= 32'd7) ? v1 + 32'd1 - 32'd8 : v1 + 32'd1;
    end
  endtask

  task automatic run_single(input int o, input int n);
    int lat, fw;
    logic b1;
    clear_mem();
    launch(o, n);
    wait_done(lat, fw, b1);
    chk("R8 R9 done latency", 32'(lat), (n == 0) ? 32'd1 : 32'(n + 2));
    chk("R8 R9 busy at first cycle", {31'd0, b1}, {31'd0, n != 0});
    chk("R8 done pair", {31'd0, done1}, 32'd1);
    if (n != 0) chk("R6 first write cycle", 32'(fw), 32'd2);
    @(negedge clk);
    chk("R8 done single cycle", {31'd0, done0}, 32'd0);
    chk("R8 idle after done", {31'd0, busy0}, 32'd0);
    verify_window(o, n);
    chk("R1 R9 write count", 32'(m0.wcnt), 32'(n));
    chk("R1 write count modulo", 32'(m1.wcnt), 32'(n));
    if (n < DEPTH) begin
      chk("R1 below window", m0.mc[(o + DEPTH - 1) % DEPTH], SENT);
      chk("R1 above window", m0.mc[(o + n) % DEPTH], SENT);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    int lat, fw;
    logic b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    clr = 1'b0;
    @(negedge clk);
    // R10 reset state
    chk("R10 busy", {31'd0, busy0}, 32'd0);
    chk("R10 done", {31'd0, done0}, 32'd0);
    chk("R10 write enable", {31'd0, cwe0}, 32'd0);
    chk("R10 modulo busy", {31'd0, busy1}, 32'd0);

    // Sweep of counts, each across several wraps of the counter.
    for (int n = 0; n <= 20; n++) run_single(n * 37 + 3, n);
    run_single(1019, 11);   // R1 address wrap
    run_single(0, DEPTH);   // full window
    run_single(512, 0);     // R9

    // R7 start while busy is ignored
    clear_mem();
    launch(200, 20);
    repeat (4) @(negedge clk);
    start = 1'b1; ofs = AW'(500); len = (AW+1)'(4);
    @(negedge clk);
    start = 1'b0;
    wait_done(lat, fw, b1);
    @(negedge clk);
    chk("R7 ignored start window", m0.mc[500], SENT);
    chk("R7 ignored start count", 32'(m0.wcnt), 32'd20);
    chk("R7 busy after run", {31'd0, busy0}, 32'd0);
    verify_window(200, 20);

    // R7 R3 start accepted in the done cycle, counter restarts
    clear_mem();
    launch(10, 5);
    wait_done(lat, fw, b1);
    start = 1'b1; ofs = AW'(600); len = (AW+1)'(7);
    @(negedge clk);
    start = 1'b0;
    wait_done(lat, fw, b1);
    chk("R7 back-to-back accepted", {31'd0, b1}, 32'd1);
    chk("R8 back-to-back latency", 32'(lat), 32'd9);
    @(negedge clk);
    verify_window(10, 5);
    verify_window(600, 7);
    chk("R3 restart count", 32'(m0.wcnt), 32'd12);

    $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule